// File: doc/BRIEF.md
# Deadtime and Shoot-Through Guard

This block sits between the filtered switching commands for one inverter leg and the gate enables of that leg's upper and lower switch. It registers both commands and drives at most one gate enable at a time. Whenever one enable drops, the opposite enable is held off for a minimum number of clock cycles. Command gaps that are already longer than that minimum pass through with no added delay.

When both commands are present, the switch that is already conducting keeps conducting. The late command is ignored. If both commands arrive while both switches are off, neither switch turns on until one command goes away. A global inhibit from the fault logic forces both enables low. Two per-side inhibits each force only their own enable low. Turn-off is never delayed.

Each output follows its command with a single register stage. The deadtime counter is shared by both directions of hand-over, so the gap is the same for a hand-over in either direction. The default of 58 cycles gives about 460 ns at 125 MHz.

Top module: `deadtime_guard`

## Requirements
- R1: `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R2: If one enable is on and its command stays asserted, that enable stays on when the opposite command also asserts. The opposite enable stays off.
- R3: After `gate_hi` falls, `gate_lo` cannot rise until both enables have been low for at least DEAD_CYC cycles. If `cmd_lo` is waiting, `gate_lo` rises after exactly DEAD_CYC cycles.
- R4: After `gate_lo` falls, `gate_hi` is held off for the same DEAD_CYC cycles as in R3.
- R5: If the opposite enable has already been low for at least DEAD_CYC cycles, a command that asserts with no competing command and no inhibit reaches its enable on the next clock edge.
- R6: While `inhibit_all` is 1, both enables are 0 from the next edge onward.
- R7: `inhibit_hi` forces only `gate_hi` to 0, and `inhibit_lo` forces only `gate_lo` to 0. The other side keeps following its command.
- R8: A deasserted command turns its enable off on the next edge, whatever the state of the deadtime counter.
- R9: If both commands are 1 while both enables are off, both enables stay off until one command is removed.
- R10: Synchronous reset (`rst` = 1) clears both enables and the deadtime counter. On the first edge after reset, either side may turn on.
- R11: An enable that dropped because of its own command or inhibit may turn on again with no deadtime wait, as long as it was the last side to turn off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_hi | input | 1 | Upper switch command (filtered) |
| cmd_lo | input | 1 | Lower switch command (filtered) |
| inhibit_all | input | 1 | Fault shutdown, forces both enables low |
| inhibit_hi | input | 1 | Forces the upper enable low |
| inhibit_lo | input | 1 | Forces the lower enable low |
| gate_hi | output | 1 | Upper switch gate enable |
| gate_lo | output | 1 | Lower switch gate enable |

## Verification
A corrupted deadtime count or a wrong record of which side turned off last shows at the ports during the next hand-over. The opposite enable then rises too early or too late, by the number of cycles the count is off, within DEAD_CYC + 1 edges of the turn-off. A wrong enable register shows one edge later as an enable that ignores its command or an inhibit. If both enables are high together, that is visible at once. The vector walk therefore checks every single cycle of a hand-over rather than only its end points.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int SIDES = 2;
    localparam int HI    = 0;
    localparam int LO    = 1;

    typedef logic [SIDES-1:0] side_vec_t;

    typedef struct packed {
        side_vec_t on;
    } gate_state_t;
endpackage

// File: rtl/dtg_gap_timer.sv
module dtg_gap_timer
    import dtg_pkg::*;
#(
    parameter int DEAD_CYC = 58,
    parameter int CNT_W    = $clog2(DEAD_CYC + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  side_vec_t fall,
    output side_vec_t blocked
);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(DEAD_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] rem;
        logic             last_lo;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (fall[HI]) begin
            tmr_d.rem     = LOAD_V;
            tmr_d.last_lo = 1'b0;
        end else if (fall[LO]) begin
            tmr_d.rem     = LOAD_V;
            tmr_d.last_lo = 1'b1;
        end else if (tmr_q.rem != '0) begin
            tmr_d.rem = tmr_q.rem - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end

    // Only the side opposite to the last turn-off waits (R11).
    assign blocked[HI] = (tmr_q.rem != '0) &  tmr_q.last_lo;
    assign blocked[LO] = (tmr_q.rem != '0) & ~tmr_q.last_lo;

    p_clear_r10: assert property (@(posedge clk) rst |=> (blocked == '0));
    p_one_block_r1: assert property (@(posedge clk) disable iff (rst) $onehot0(blocked));
endmodule

// File: rtl/dtg_side_gate.sv
module dtg_side_gate (
    input  logic own_cmd,
    input  logic other_cmd,
    input  logic own_on,
    input  logic other_on,
    input  logic own_blocked,
    input  logic inhibit,
    output logic own_next
);
    logic may_start;

    always_comb begin
        may_start = ~other_on & ~other_cmd & ~own_blocked;
        own_next  = ~inhibit & own_cmd & (own_on | may_start);
    end
endmodule

// File: rtl/deadtime_guard.sv
module deadtime_guard
    import dtg_pkg::*;
#(
    parameter int DEAD_CYC = 58
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_hi,
    input  logic cmd_lo,
    input  logic inhibit_all,
    input  logic inhibit_hi,
    input  logic inhibit_lo,
    output logic gate_hi,
    output logic gate_lo
);
    localparam int               CNT_W  = $clog2(DEAD_CYC + 1);
    localparam logic [CNT_W-1:0] DEAD_V = CNT_W'(DEAD_CYC);

    gate_state_t state_d, state_q;
    side_vec_t   cmd_v, inh_v, blocked_v, next_v, fall_v;

    assign cmd_v[HI] = cmd_hi;
    assign cmd_v[LO] = cmd_lo;
    assign inh_v[HI] = inhibit_all | inhibit_hi;
    assign inh_v[LO] = inhibit_all | inhibit_lo;

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dtg_side_gate u_side (
            .own_cmd     (cmd_v[s]),
            .other_cmd   (cmd_v[SIDES-1-s]),
            .own_on      (state_q.on[s]),
            .other_on    (state_q.on[SIDES-1-s]),
            .own_blocked (blocked_v[s]),
            .inhibit     (inh_v[s]),
            .own_next    (next_v[s])
        );
    end

    always_comb begin
        state_d    = state_q;
        state_d.on = next_v;
        fall_v     = state_q.on & ~state_d.on;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    dtg_gap_timer #(.DEAD_CYC(DEAD_CYC), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .fall    (fall_v),
        .blocked (blocked_v)
    );

    assign gate_hi = state_q.on[HI];
    assign gate_lo = state_q.on[LO];

    // Checker: cycles each enable has been low, saturating at DEAD_CYC.
    logic [CNT_W-1:0] hi_quiet_q, lo_quiet_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_quiet_q <= DEAD_V;
            lo_quiet_q <= DEAD_V;
        end else begin
            hi_quiet_q <= gate_hi ? '0 : ((hi_quiet_q == DEAD_V) ? DEAD_V : hi_quiet_q + 1'b1);
            lo_quiet_q <= gate_lo ? '0 : ((lo_quiet_q == DEAD_V) ? DEAD_V : lo_quiet_q + 1'b1);
        end
    end

    p_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi && gate_lo));
    p_keep_on_r2: assert property (@(posedge clk) disable iff (rst)
        (gate_hi && cmd_hi && !inhibit_all && !inhibit_hi) |=> gate_hi);
    p_gap_lo_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_lo) |-> (hi_quiet_q >= DEAD_V));
    p_gap_hi_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi) |-> (lo_quiet_q >= DEAD_V));
    p_no_stretch_r5: assert property (@(posedge clk) disable iff (rst)
        (!gate_hi && hi_quiet_q >= DEAD_V && cmd_lo && !cmd_hi &&
         !inhibit_all && !inhibit_lo) |=> gate_lo);
    p_inhibit_r6: assert property (@(posedge clk) disable iff (rst)
        inhibit_all |=> (!gate_hi && !gate_lo));
    p_side_inh_r7: assert property (@(posedge clk) disable iff (rst)
        (inhibit_hi || inhibit_lo) |=> !((gate_hi && $past(inhibit_hi)) || (gate_lo && $past(inhibit_lo))));
    p_turn_off_r8: assert property (@(posedge clk) disable iff (rst)
        (!cmd_hi || !cmd_lo) |=> !((gate_hi && !$past(cmd_hi)) || (gate_lo && !$past(cmd_lo))));
    p_both_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!gate_hi && !gate_lo && cmd_hi && cmd_lo) |=> (!gate_hi && !gate_lo));
endmodule

// File: tb/deadtime_guard_test.sv
module deadtime_guard_test;
    localparam int DEAD = 4;
    localparam int NV   = 35;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_hi = 1'b0, cmd_lo = 1'b0;
    logic inh_all = 1'b0, inh_hi = 1'b0, inh_lo = 1'b0;
    logic gate_hi, gate_lo;
    int   checks = 0;
    int   errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    deadtime_guard #(.DEAD_CYC(DEAD)) uut (
        .clk(clk), .rst(rst), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .inhibit_all(inh_all), .inhibit_hi(inh_hi), .inhibit_lo(inh_lo),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    // {cmd_hi, cmd_lo, inh_all, inh_hi, inh_lo, exp_hi, exp_lo}
    // Expected value is the output after the edge that samples the inputs.
    localparam logic [6:0] VEC [NV] = '{
        7'b1000010,  // R5 upper turns on at once after reset
        7'b1100010,  // R2 lower command ignored while upper on
        7'b0100000,  // R8 upper off immediately
        7'b0100000,  // R3 waiting 1
        7'b0100000,  // R3 waiting 2
        7'b0100000,  // R3 waiting 3
        7'b0100001,  // R3 lower on after 4 low cycles
        7'b1100001,  // R2 upper command ignored while lower on
        7'b1000000,  // R8 lower off immediately
        7'b1000000,  // R4 waiting 1
        7'b1000000,  // R4 waiting 2
        7'b1000000,  // R4 waiting 3
        7'b1000010,  // R4 upper on after 4 low cycles
        7'b0000000,  // R8
        7'b0000000,  // R1 idle
        7'b0000000,  // R1 idle
        7'b0000000,  // R1 idle
        7'b0000000,  // R1 idle
        7'b0100001,  // R5 long gap, no extension
        7'b0110000,  // R6 global inhibit
        7'b0100001,  // R11 same side relights at once
        7'b0100100,  // R7 lower inhibit
        7'b1000000,  // R4 upper waits after lower fell
        7'b1001000,  // R7 upper inhibit
        7'b1000000,  // R4 still waiting
        7'b1000010,  // R4 upper on
        7'b1000110,  // R7 lower inhibit leaves upper alone
        7'b0000000,  // R8
        7'b0000000,  // R1 idle
        7'b0000000,  // R1 idle
        7'b0000000,  // R1 idle
        7'b1100000,  // R9 both commands while idle
        7'b1100000,  // R9 still none
        7'b1000010,  // R9 one removed, upper on
        7'b0000000   // R8
    };
    localparam int VREQ [NV] = '{5,2,8,3,3,3,3,2,8,4,4,4,4,8,1,1,1,1,5,6,11,7,4,7,4,4,7,8,1,1,1,9,9,9,8};

    task automatic check(input string req, input logic eh, input logic el);
        checks++;
        if (gate_hi !== eh || gate_lo !== el) begin
            errors++;
            $display("FAIL %s: gate_hi/gate_lo=%b%b expected %b%b", req, gate_hi, gate_lo, eh, el);
        end
    endtask

    task automatic drive(input logic [6:0] v);
        {cmd_hi, cmd_lo, inh_all, inh_hi, inh_lo} = v[6:2];
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10", 1'b0, 1'b0);              // reset state
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check($sformatf("R%0d vec%0d", VREQ[i], i), VEC[i][1], VEC[i][0]);
        end
        // R10: reset in mid-conduction, then the opposite side starts at once.
        drive(7'b1000000);
        @(negedge clk);
        check("R5", 1'b1, 1'b0);
        rst = 1'b1;
        drive(7'b0100000);
        @(negedge clk);
        check("R10 reset clears", 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 no wait after reset", 1'b0, 1'b1);
        // R3 exact gap with default-style sweep: hand over and count.
        drive(7'b1000000);
        @(negedge clk);
        check("R8 lower off", 1'b0, 1'b0);
        for (int k = 1; k < DEAD; k++) begin
            @(negedge clk);
            check("R4 held during gap", 1'b0, 1'b0);
        end
        @(negedge clk);
        check("R4 on after gap", 1'b1, 1'b0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        finish_run();
    end
endmodule